// File: doc/BRIEF.md
# Fixed-Point Execution Unit with Signed Compares

This block is the arithmetic core of a small pipelined RISC processor. It is purely combinational. In a single evaluation it takes a first operand and a second operand and produces a 32-bit result. The second operand is either a register value or a 16-bit immediate, sign-extended to the data width. A second 32-bit output carries the upper half of a product.

The decoder supplies a 5-bit operation code and a flag that chooses the immediate form. The unit covers four groups of operations:

- wrapping add and subtract;
- six bitwise logic operations, including the three complemented ones;
- logical shifts in both directions;
- six set-on-compare results and a full signed multiply.

All compare decisions come from the same subtractor that serves the subtract operation. The decision uses the sign of the difference, corrected by signed overflow. The shifter and the multiplier each come in two build variants, chosen by parameter.

Top module: `alu_exec`

## Requirements
- R1: Code 0 returns A+B and code 1 returns A−B, with the first operand A as the minuend. Both wrap modulo 2^32.
- R2: The logic codes are applied bitwise across all 32 bits: 2 AND, 3 OR, 4 XOR, 5 NAND, 6 NOR, 7 XNOR.
- R3: Code 8 shifts A left and code 9 shifts A right by the value of bits [4:0] of B. Higher bits of B are ignored. Vacated bit positions fill with zeros in both directions.
- R4: The compare codes are 10 GE, 11 GT, 12 LE, 13 LT, 14 EQ and 15 NE. Each compares A against B as two's-complement signed values and returns 1 when the condition holds and 0 otherwise. The result stays correct when A−B overflows, for example 0x80000000 against 0x7FFFFFFF.
- R5: Code 16 forms the signed 64-bit product of A and B. The low 32 bits go to the low result output and the high 32 bits go to the high result output.
- R6: When the immediate flag is 1, B is the 16-bit immediate sign-extended to 32 bits and the register operand has no effect. When the flag is 0, B is the register operand.
- R7: The high result output is zero for every code other than 16.
- R8: Codes 17 to 31 are unassigned and drive zero on both result outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 5 | Operation code |
| use_imm_i | input | 1 | 1 selects the sign-extended immediate as operand B |
| a_i | input | 32 | Operand A (first source register) |
| b_i | input | 32 | Register form of operand B |
| imm_i | input | 16 | Immediate field |
| res_lo_o | output | 32 | Main result, low product half for multiply |
| res_hi_o | output | 32 | High product half for multiply, else zero |

## Verification
The hardest case to reach is a compare whose subtraction overflows. Taking the sign of A−B alone then gives the wrong answer, and random operands seldom produce it. The stimulus forces it directly. It pairs the most negative and most positive values in both orders, and it pairs each extreme against small values of the opposite sign. It also covers equal operands and operands one apart, so that the boundary between GE and GT (and between LE and LT) is crossed. The immediate form is checked with immediates that have bit 15 set, while the register input carries a conflicting value.

// File: rtl/alu_exec_pkg.sv
package alu_exec_pkg;

   typedef enum logic [4:0] {
      OP_ADD  = 5'd0,
      OP_SUB  = 5'd1,
      OP_AND  = 5'd2,
      OP_OR   = 5'd3,
      OP_XOR  = 5'd4,
      OP_NAND = 5'd5,
      OP_NOR  = 5'd6,
      OP_XNOR = 5'd7,
      OP_SHL  = 5'd8,
      OP_SHR  = 5'd9,
      OP_SGE  = 5'd10,
      OP_SGT  = 5'd11,
      OP_SLE  = 5'd12,
      OP_SLT  = 5'd13,
      OP_SEQ  = 5'd14,
      OP_SNE  = 5'd15,
      OP_MUL  = 5'd16
   } alu_op_e;

   typedef enum logic [2:0] {
      LG_AND  = 3'd0,
      LG_OR   = 3'd1,
      LG_XOR  = 3'd2,
      LG_NAND = 3'd3,
      LG_NOR  = 3'd4,
      LG_XNOR = 3'd5
   } logic_fn_e;

endpackage

// File: rtl/alu_operand_sel.sv
module alu_operand_sel #(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 16
) (
   input  logic [DATA_W-1:0] reg_b_i,
   input  logic [IMM_W-1:0]  imm_i,
   input  logic              use_imm_i,
   output logic [DATA_W-1:0] b_o
);
   localparam int EXT_W = DATA_W - IMM_W;

   logic [DATA_W-1:0] imm_ext;

   generate
      if (EXT_W > 0) begin : g_ext
         assign imm_ext = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
      end else begin : g_noext
         assign imm_ext = imm_i[DATA_W-1:0];
      end
   endgenerate

   assign b_o = use_imm_i ? imm_ext : reg_b_i;
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic              sub_i,
   output logic [DATA_W-1:0] sum_o,
   output logic              lt_o,
   output logic              eq_o
);
   localparam int MSB = DATA_W - 1;

   logic [DATA_W-1:0] b_eff;
   logic              ovf;

   assign b_eff = sub_i ? ~b_i : b_i;
   assign sum_o = a_i + b_eff + {{(DATA_W-1){1'b0}}, sub_i};

   // overflow of a subtraction: operand signs differ and result sign differs from A
   assign ovf  = (a_i[MSB] ^ b_i[MSB]) & (sum_o[MSB] ^ a_i[MSB]);
   assign lt_o = sum_o[MSB] ^ ovf;
   assign eq_o = (sum_o == '0);
endmodule

// File: rtl/alu_logic.sv
module alu_logic
   import alu_exec_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic_fn_e         fn_i,
   output logic [DATA_W-1:0] y_o
);
   always_comb begin
      unique case (fn_i)
         LG_AND:  y_o = a_i & b_i;
         LG_OR:   y_o = a_i | b_i;
         LG_XOR:  y_o = a_i ^ b_i;
         LG_NAND: y_o = ~(a_i & b_i);
         LG_NOR:  y_o = ~(a_i | b_i);
         LG_XNOR: y_o = ~(a_i ^ b_i);
         default: y_o = '0;
      endcase
   end
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
   parameter int DATA_W      = 32,
   parameter int SHIFT_STYLE = 1,   // 0: operator, 1: explicit log stages
   localparam int AMT_W      = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [AMT_W-1:0]  amt_i,
   input  logic              left_i,
   output logic [DATA_W-1:0] y_o
);
   generate
      if (SHIFT_STYLE == 0) begin : g_op
         assign y_o = left_i ? (a_i << amt_i) : (a_i >> amt_i);
      end else begin : g_barrel
         logic [DATA_W-1:0] stage [AMT_W+1];
         assign stage[0] = a_i;
         for (genvar k = 0; k < AMT_W; k++) begin : g_stage
            localparam int DIST = 1 << k;
            logic [DATA_W-1:0] moved;
            assign moved = left_i ? {stage[k][DATA_W-1-DIST:0], {DIST{1'b0}}}
                                  : {{DIST{1'b0}}, stage[k][DATA_W-1:DIST]};
            assign stage[k+1] = amt_i[k] ? moved : stage[k];
         end
         assign y_o = stage[AMT_W];
      end
   endgenerate
endmodule

// File: rtl/alu_mul.sv
module alu_mul #(
   parameter int DATA_W    = 32,
   parameter int MUL_STYLE = 0,     // 0: operator, 1: partial-product rows
   localparam int PROD_W   = 2 * DATA_W
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   output logic [PROD_W-1:0] p_o
);
   logic [PROD_W-1:0] a_ext;
   logic [PROD_W-1:0] b_ext;

   assign a_ext = {{DATA_W{a_i[DATA_W-1]}}, a_i};
   assign b_ext = {{DATA_W{b_i[DATA_W-1]}}, b_i};

   generate
      if (MUL_STYLE == 0) begin : g_op
         assign p_o = $signed(a_ext) * $signed(b_ext);
      end else begin : g_rows
         // the sign row carries negative weight in two's complement
         always_comb begin
            p_o = '0;
            for (int i = 0; i < DATA_W; i++) begin
               if (b_i[i]) begin
                  if (i == DATA_W - 1) p_o = p_o - (a_ext << i);
                  else                 p_o = p_o + (a_ext << i);
               end
            end
         end
      end
   endgenerate
endmodule

// File: rtl/alu_exec.sv
module alu_exec
   import alu_exec_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int IMM_W       = 16,
   parameter int SHIFT_STYLE = 1,
   parameter int MUL_STYLE   = 0
) (
   input  logic [4:0]        op_i,
   input  logic              use_imm_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   input  logic [IMM_W-1:0]  imm_i,
   output logic [DATA_W-1:0] res_lo_o,
   output logic [DATA_W-1:0] res_hi_o
);
   localparam int AMT_W  = $clog2(DATA_W);
   localparam int PROD_W = 2 * DATA_W;

   generate
      if (IMM_W > DATA_W) begin : g_bad_imm
         $error("alu_exec: IMM_W must not exceed DATA_W");
      end
      if ((1 << AMT_W) != DATA_W) begin : g_bad_w
         $error("alu_exec: DATA_W must be a power of two");
      end
      if (SHIFT_STYLE < 0 || SHIFT_STYLE > 1) begin : g_bad_sh
         $error("alu_exec: SHIFT_STYLE must be 0 or 1");
      end
      if (MUL_STYLE < 0 || MUL_STYLE > 1) begin : g_bad_mul
         $error("alu_exec: MUL_STYLE must be 0 or 1");
      end
   endgenerate

   alu_op_e           op;
   logic [DATA_W-1:0] opb;
   logic [DATA_W-1:0] sum;
   logic              lt;
   logic              eq;
   logic [DATA_W-1:0] lg_y;
   logic [DATA_W-1:0] sh_y;
   logic [PROD_W-1:0] prod;
   logic_fn_e         lg_fn;
   logic              do_sub;
   logic              cmp_hit;

   assign op     = alu_op_e'(op_i);
   assign do_sub = (op != OP_ADD);

   always_comb begin
      unique case (op)
         OP_OR:   lg_fn = LG_OR;
         OP_XOR:  lg_fn = LG_XOR;
         OP_NAND: lg_fn = LG_NAND;
         OP_NOR:  lg_fn = LG_NOR;
         OP_XNOR: lg_fn = LG_XNOR;
         default: lg_fn = LG_AND;
      endcase
   end

   alu_operand_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opsel (
      .reg_b_i   (b_i),
      .imm_i     (imm_i),
      .use_imm_i (use_imm_i),
      .b_o       (opb)
   );

   alu_addsub #(.DATA_W(DATA_W)) u_addsub (
      .a_i   (a_i),
      .b_i   (opb),
      .sub_i (do_sub),
      .sum_o (sum),
      .lt_o  (lt),
      .eq_o  (eq)
   );

   alu_logic #(.DATA_W(DATA_W)) u_logic (
      .a_i  (a_i),
      .b_i  (opb),
      .fn_i (lg_fn),
      .y_o  (lg_y)
   );

   alu_shift #(.DATA_W(DATA_W), .SHIFT_STYLE(SHIFT_STYLE)) u_shift (
      .a_i    (a_i),
      .amt_i  (opb[AMT_W-1:0]),
      .left_i (op == OP_SHL),
      .y_o    (sh_y)
   );

   alu_mul #(.DATA_W(DATA_W), .MUL_STYLE(MUL_STYLE)) u_mul (
      .a_i (a_i),
      .b_i (opb),
      .p_o (prod)
   );

   always_comb begin
      unique case (op)
         OP_SGE:  cmp_hit = ~lt;
         OP_SGT:  cmp_hit = ~lt & ~eq;
         OP_SLE:  cmp_hit = lt | eq;
         OP_SLT:  cmp_hit = lt;
         OP_SEQ:  cmp_hit = eq;
         OP_SNE:  cmp_hit = ~eq;
         default: cmp_hit = 1'b0;
      endcase
   end

   always_comb begin
      res_hi_o = '0;
      unique case (op)
         OP_ADD, OP_SUB:                     res_lo_o = sum;
         OP_AND, OP_OR, OP_XOR,
         OP_NAND, OP_NOR, OP_XNOR:           res_lo_o = lg_y;
         OP_SHL, OP_SHR:                     res_lo_o = sh_y;
         OP_SGE, OP_SGT, OP_SLE,
         OP_SLT, OP_SEQ, OP_SNE:             res_lo_o = {{(DATA_W-1){1'b0}}, cmp_hit};
         OP_MUL: begin
            res_lo_o = prod[DATA_W-1:0];
            res_hi_o = prod[PROD_W-1:DATA_W];
         end
         default:                            res_lo_o = '0;
      endcase
   end
endmodule

// File: rtl/alu_exec_chk.sv
module alu_exec_chk #(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 16
) (
   input logic [4:0]        op_i,
   input logic              use_imm_i,
   input logic [DATA_W-1:0] a_i,
   input logic [DATA_W-1:0] b_i,
   input logic [IMM_W-1:0]  imm_i,
   input logic [DATA_W-1:0] res_lo_o,
   input logic [DATA_W-1:0] res_hi_o
);
   logic signed [DATA_W-1:0] sa;
   logic signed [DATA_W-1:0] sb;
   logic                     known;

   assign sa    = $signed(a_i);
   assign sb    = use_imm_i ? $signed({{(DATA_W-IMM_W){imm_i[IMM_W-1]}}, imm_i})
                            : $signed(b_i);
   assign known = !$isunknown({op_i, use_imm_i, a_i, b_i, imm_i});

   always_comb begin
      if (known) begin
         if (op_i != 5'd16)
            assert_hi_quiet_R7: assert (res_hi_o == '0)
               else $error("high word nonzero for op %0d", op_i);
         if (op_i >= 5'd10 && op_i <= 5'd15)
            assert_set_is_bit_R4: assert (res_lo_o[DATA_W-1:1] == '0)
               else $error("set result wider than one bit");
         if (op_i == 5'd13)
            assert_lt_signed_R4: assert (res_lo_o[0] == (sa < sb))
               else $error("signed less-than mismatch");
         if (op_i == 5'd10)
            assert_ge_signed_R4: assert (res_lo_o[0] == (sa >= sb))
               else $error("signed greater-or-equal mismatch");
         if (op_i == 5'd1)
            assert_sub_order_R1: assert (res_lo_o + sb == sa)
               else $error("difference does not restore A");
         if (op_i > 5'd16)
            assert_unassigned_zero_R8: assert (res_lo_o == '0 && res_hi_o == '0)
               else $error("unassigned code produced data");
      end
   end
endmodule

bind alu_exec alu_exec_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_chk (
   .op_i      (op_i),
   .use_imm_i (use_imm_i),
   .a_i       (a_i),
   .b_i       (b_i),
   .imm_i     (imm_i),
   .res_lo_o  (res_lo_o),
   .res_hi_o  (res_hi_o)
);

// File: tb/tb_alu_exec.sv
module tb_alu_exec;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [4:0]  op;
   logic        use_imm;
   logic [31:0] a, b;
   logic [15:0] imm;
   logic [31:0] lo, hi;

   int n_chk  = 0;
   int n_fail = 0;
   int cycles = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   alu_exec dut (
      .op_i      (op),
      .use_imm_i (use_imm),
      .a_i       (a),
      .b_i       (b),
      .imm_i     (imm),
      .res_lo_o  (lo),
      .res_hi_o  (hi)
   );

   function automatic logic [63:0] model(input logic [4:0] o, input logic [31:0] x,
                                         input logic [31:0] y);
      longint sx = longint'($signed(x));
      longint sy = longint'($signed(y));
      logic [31:0] r = 32'd0;
      logic [31:0] h = 32'd0;
      logic [63:0] p;
      case (o)
         5'd0:  r = x + y;
         5'd1:  r = x - y;
         5'd2:  r = x & y;
         5'd3:  r = x | y;
         5'd4:  r = x ^ y;
         5'd5:  r = ~(x & y);
         5'd6:  r = ~(x | y);
         5'd7:  r = ~(x ^ y);
         5'd8:  r = x << y[4:0];
         5'd9:  r = x >> y[4:0];
         5'd10: r = {31'd0, sx >= sy};
         5'd11: r = {31'd0, sx >  sy};
         5'd12: r = {31'd0, sx <= sy};
         5'd13: r = {31'd0, sx <  sy};
         5'd14: r = {31'd0, sx == sy};
         5'd15: r = {31'd0, sx != sy};
         5'd16: begin p = sx * sy; r = p[31:0]; h = p[63:32]; end
         default: begin r = 32'd0; h = 32'd0; end
      endcase
      return {h, r};
   endfunction

   task automatic check(input string tag, input logic [4:0] o, input logic [31:0] x,
                        input logic [31:0] y, input logic ui, input logic [15:0] im);
      logic [31:0] eb;
      logic [63:0] exp_v;
      @(negedge clk);
      op = o; a = x; b = y; use_imm = ui; imm = im;
      #1;
      eb    = ui ? {{16{im[15]}}, im} : y;
      exp_v = model(o, x, eb);
      n_chk++;
      if ({hi, lo} !== exp_v) begin
         n_fail++;
         $display("FAIL %s op=%0d a=%h b=%h imm=%h ui=%0b actual=%h_%h expected=%h_%h",
                  tag, o, x, y, im, ui, hi, lo, exp_v[63:32], exp_v[31:0]);
      end
   endtask

   task automatic t_idle();   // all-zero inputs after reset
      check("R1 idle", 5'd0, 32'd0, 32'd0, 1'b0, 16'd0);
   endtask

   task automatic t_arith();
      check("R1 add", 5'd0, 32'd5, 32'd7, 1'b0, 16'd0);
      check("R1 add wrap", 5'd0, 32'hFFFF_FFFF, 32'd2, 1'b0, 16'd0);
      check("R1 sub order", 5'd1, 32'd3, 32'd10, 1'b0, 16'd0);
      check("R1 sub", 5'd1, 32'h8000_0000, 32'd1, 1'b0, 16'd0);
   endtask

   task automatic t_logic();
      for (int o = 2; o <= 7; o++) begin
         check("R2 logic", 5'(o), 32'hF0F0_A5A5, 32'hFF00_3C3C, 1'b0, 16'd0);
         check("R2 logic zeros", 5'(o), 32'd0, 32'hFFFF_FFFF, 1'b0, 16'd0);
      end
   endtask

   task automatic t_shift();
      check("R3 shl 0", 5'd8, 32'h8000_0001, 32'd0, 1'b0, 16'd0);
      check("R3 shl 31", 5'd8, 32'h0000_0003, 32'd31, 1'b0, 16'd0);
      check("R3 shr 31", 5'd9, 32'h8000_0000, 32'd31, 1'b0, 16'd0);
      check("R3 shr zero fill", 5'd9, 32'hF000_0000, 32'd4, 1'b0, 16'd0);
      check("R3 high amt bits", 5'd8, 32'h0000_0001, 32'h0000_0123, 1'b0, 16'd0);
      check("R3 shr imm", 5'd9, 32'hFFFF_FFFF, 32'd0, 1'b1, 16'hFFE1);
   endtask

   task automatic t_compare();
      logic [31:0] v [6] = '{32'h8000_0000, 32'h7FFF_FFFF, 32'd0, 32'hFFFF_FFFF,
                             32'd1, 32'h8000_0001};
      for (int o = 10; o <= 15; o++)
         for (int i = 0; i < 6; i++)
            for (int j = 0; j < 6; j++)
               check("R4 compare", 5'(o), v[i], v[j], 1'b0, 16'd0);
   endtask

   task automatic t_mul();
      check("R5 mul small", 5'd16, 32'd6, 32'd7, 1'b0, 16'd0);
      check("R5 mul neg", 5'd16, 32'hFFFF_FFFF, 32'd5, 1'b0, 16'd0);
      check("R5 mul min", 5'd16, 32'h8000_0000, 32'h8000_0000, 1'b0, 16'd0);
      check("R5 mul max", 5'd16, 32'h7FFF_FFFF, 32'h8000_0000, 1'b0, 16'd0);
   endtask

   task automatic t_imm();
      check("R6 imm neg add", 5'd0, 32'd100, 32'h1234_5678, 1'b1, 16'hFFFF);
      check("R6 imm pos sub", 5'd1, 32'd100, 32'hDEAD_BEEF, 1'b1, 16'h7FFF);
      check("R6 imm cmp", 5'd13, 32'd0, 32'hFFFF_FFFF, 1'b1, 16'h8000);
      check("R6 imm mul", 5'd16, 32'd3, 32'd9, 1'b1, 16'hFFFE);
   endtask

   task automatic t_hi_quiet();
      for (int o = 0; o < 16; o++)
         check("R7 hi zero", 5'(o), 32'hFFFF_FFFF, 32'h8000_0000, 1'b0, 16'd0);
   endtask

   task automatic t_unassigned();
      for (int o = 17; o < 32; o++)
         check("R8 unassigned", 5'(o), 32'h1234_5678, 32'h9ABC_DEF0, 1'b0, 16'd0);
   endtask

   task automatic t_random();
      for (int n = 0; n < 2000; n++)
         check("R1 R2 R3 R4 R5 R6 random", 5'($urandom_range(16, 0)), $urandom, $urandom,
               1'($urandom), 16'($urandom));
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog expired actual=%0d expected<150000 cycles", cycles);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      op = '0; use_imm = 1'b0; a = '0; b = '0; imm = '0;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      t_idle();
      t_arith();
      t_logic();
      t_shift();
      t_compare();
      t_mul();
      t_imm();
      t_hi_quiet();
      t_unassigned();
      t_random();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end
endmodule